// File: doc/BRIEF.md
# Frame-Synchronised Serial PCM Port

This block is the serial edge of a telephony codec channel. It runs on a single 2.048 MHz bit clock and handles a single 8-bit timeslot per frame. The slot opens when an active-low frame-sync input is seen low on a rising clock edge. In the eight clocks that follow, the port sends one word out on a serial data output that has an enable. The word goes MSB first, with a new bit launched on each rising edge. In the same clocks, the port shifts one word in from a serial data input and one control word in from a separate serial control input. Both inputs are sampled on falling edges. Outside the slot the output is not driven.

The codec core supplies the parallel transmit word. It receives the captured PCM word and the captured control word, each with a one-cycle valid strobe. A 2-bit register-select input gives the slot's purpose. When it names the second control register, the slot carries only a control word and PCM transfer is inhibited. A loopback input makes the next slot send back the most recently captured PCM word in place of the core's transmit word.

Top module: `pcm_slot_port`

## Requirements
- R1: While rstN is low, and after it is released until the first slot, serDataOe, rxValid and ctlValid are 0 and rxWord, ctlWord and serDataOut read 0.
- R2: A slot starts on the first rising edge at which frameSyncN is sampled low while no slot is running. From that edge on, serDataOe is 1 and serDataOut carries bit 7 of the outgoing word.
- R3: In each of the next 7 rising edges, serDataOut moves to the next lower bit (bit 6 down to bit 0). serDataOe stays high for exactly 8 clocks, never longer. Whenever serDataOe is 0, serDataOut reads 0.
- R4: serDataIn is sampled on the falling edge that follows each of the slot's 8 rising edges. The first sample becomes bit 7 of rxWord and the last becomes bit 0.
- R5: frameSyncN is ignored while a slot runs. If it is still low at the ninth rising edge, that edge ends the slot with the output released, and the next slot starts one edge later.
- R6: serCtlIn is sampled on the same falling edges as serDataIn, MSB first, in every slot. The result appears on ctlWord.
- R7: regSel is sampled when the slot starts. The code 2'b10 (positive level) selects the second register: serDataOe stays 0, rxWord keeps its old value, rxValid stays low, and ctlToB is 1. The codes 2'b00, 2'b01 and 2'b11 select normal PCM transfer with ctlToB 0.
- R8: rxValid (PCM slots only) and ctlValid (every slot) rise for exactly one cycle. They are set at the rising edge that follows the slot's eighth falling edge. rxWord and ctlWord hold their values between strobes.
- R9: loopbackEn and txWord are sampled when the slot starts. With loopbackEn set to 1, the slot sends the current rxWord. With it at 0, the slot sends txWord. Changes to either input after the start do not affect the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSyncN | input | 1 | Active-low slot enable, sampled on rising edges |
| regSel | input | 2 | Register select: 00 negative, 01 ground, 10 positive level |
| serDataIn | input | 1 | Serial PCM data in, sampled on falling edges |
| serCtlIn | input | 1 | Serial control word in, sampled on falling edges |
| loopbackEn | input | 1 | Send back the last captured PCM word |
| txWord | input | 8 | Parallel outgoing PCM word from the core |
| serDataOut | output | 1 | Serial PCM data out, launched on rising edges |
| serDataOe | output | 1 | Output enable for the three-state serial output |
| rxWord | output | 8 | Last captured PCM word |
| rxValid | output | 1 | One-cycle strobe: new rxWord |
| ctlWord | output | 8 | Last captured control word |
| ctlValid | output | 1 | One-cycle strobe: new ctlWord |
| ctlToB | output | 1 | The last control word targets the second register |

## Verification
Directed slots use complementary and all-zero/all-one words on data and control. A bit-order or edge-alignment slip therefore shows up as a wrong value rather than as a symmetric match. A slot with the second-register code shows that PCM transfer is inhibited while the control word is still taken. A loopback slot checks that the sent word is the earlier capture and not txWord. A frame sync held low past the eighth clock tells slot termination apart from re-triggering. Random slots then mix all four select codes, the loopback setting, idle gaps of varying length, and transmit-word changes made after the start, which expose any input sampled at the wrong moment.

// File: rtl/pcm_port_pkg.sv
`timescale 1ns/1ps
package pcm_port_pkg;
  parameter int unsigned WORD_BITS = 8;
  localparam int unsigned IDX_W = $clog2(WORD_BITS);

  typedef enum logic [1:0] {
    SEL_NEG = 2'b00,
    SEL_GND = 2'b01,
    SEL_POS = 2'b10,
    SEL_RSV = 2'b11
  } reg_sel_e;

  // strobes from the slot controller to the datapath
  typedef struct packed {
    logic             start;   // idle and frame sync low on this edge
    logic             active;  // slot running
    logic [IDX_W-1:0] bitIdx;  // bit position within the slot
    logic             last;    // final bit of the slot
    logic             pcmEn;   // PCM transfer allowed in this slot
    logic             toB;     // control word aimed at second register
  } slot_strb_t;
endpackage

// File: rtl/pcm_slot_ctrl.sv
`timescale 1ns/1ps
module pcm_slot_ctrl
  import pcm_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameSyncN,
  input  logic [1:0] regSel,
  output slot_strb_t strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BITS - 1);

  logic             active;
  logic [IDX_W-1:0] bitIdx;
  logic             pcmEn;
  logic             toB;
  logic             start;
  logic             last;

  assign start = !active && !frameSyncN;
  assign last  = active && (bitIdx == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitIdx <= '0;
      pcmEn  <= 1'b0;
      toB    <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      bitIdx <= '0;
      toB    <= (reg_sel_e'(regSel) == SEL_POS);
      pcmEn  <= (reg_sel_e'(regSel) != SEL_POS);
    end else if (active) begin
      if (last) begin
        active <= 1'b0;
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.start  = start;
    strb.active = active;
    strb.bitIdx = bitIdx;
    strb.last   = last;
    strb.pcmEn  = pcmEn;
    strb.toB    = toB;
  end

  // R2
  slot_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !frameSyncN) |=> (active && bitIdx == '0));

  // R5
  slot_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    last |=> !active);

  // R7
  sel_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !last) |=> ($stable(toB) && $stable(pcmEn)));
endmodule

// File: rtl/pcm_slot_dp.sv
`timescale 1ns/1ps
module pcm_slot_dp
  import pcm_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  slot_strb_t           strb,
  input  logic                 serDataIn,
  input  logic                 serCtlIn,
  input  logic                 loopbackEn,
  input  logic [WORD_BITS-1:0] txWord,
  output logic                 serDataOut,
  output logic                 serDataOe,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid,
  output logic [WORD_BITS-1:0] ctlWord,
  output logic                 ctlValid,
  output logic                 ctlToB
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_BITS - 1);
  localparam int unsigned RUN_W = $clog2(WORD_BITS + 1) + 1;

  logic [WORD_BITS-1:0] txHold;
  logic [WORD_BITS-1:0] rxShift;
  logic [WORD_BITS-1:0] ctlShift;

  // transmit word latched at slot start, then launched on rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           txHold <= '0;
    else if (strb.start) txHold <= loopbackEn ? rxWord : txWord;
  end

  assign serDataOe  = strb.active && strb.pcmEn;
  assign serDataOut = serDataOe && txHold[TOP_IDX - strb.bitIdx];

  // serial capture on falling edges, half a bit after each launch
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      ctlShift <= '0;
    end else if (strb.active) begin
      ctlShift <= {ctlShift[WORD_BITS-2:0], serCtlIn};
      if (strb.pcmEn) rxShift <= {rxShift[WORD_BITS-2:0], serDataIn};
    end
  end

  // parallel hand-over to the core on the edge closing the slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWord   <= '0;
      rxValid  <= 1'b0;
      ctlWord  <= '0;
      ctlValid <= 1'b0;
      ctlToB   <= 1'b0;
    end else begin
      rxValid  <= 1'b0;
      ctlValid <= 1'b0;
      if (strb.last) begin
        ctlWord  <= ctlShift;
        ctlValid <= 1'b1;
        ctlToB   <= strb.toB;
        if (strb.pcmEn) begin
          rxWord  <= rxShift;
          rxValid <= 1'b1;
        end
      end
    end
  end

  // run length of the output enable, for the window check
  logic [RUN_W-1:0] oeRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          oeRun <= '0;
    else if (serDataOe) oeRun <= oeRun + 1'b1;
    else                oeRun <= '0;
  end

  // R3
  oe_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    serDataOe |-> (oeRun < RUN_W'(WORD_BITS)));

  // R8
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> ($stable(rxWord) || rxValid));

  // R7
  b_inhibit_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (ctlValid && !ctlToB));
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
  import pcm_port_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameSyncN,
  input  logic [1:0]           regSel,
  input  logic                 serDataIn,
  input  logic                 serCtlIn,
  input  logic                 loopbackEn,
  input  logic [WORD_BITS-1:0] txWord,
  output logic                 serDataOut,
  output logic                 serDataOe,
  output logic [WORD_BITS-1:0] rxWord,
  output logic                 rxValid,
  output logic [WORD_BITS-1:0] ctlWord,
  output logic                 ctlValid,
  output logic                 ctlToB
);
  slot_strb_t slotStrb;

  pcm_slot_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameSyncN (frameSyncN),
    .regSel     (regSel),
    .strb       (slotStrb)
  );

  pcm_slot_dp uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (slotStrb),
    .serDataIn  (serDataIn),
    .serCtlIn   (serCtlIn),
    .loopbackEn (loopbackEn),
    .txWord     (txWord),
    .serDataOut (serDataOut),
    .serDataOe  (serDataOe),
    .rxWord     (rxWord),
    .rxValid    (rxValid),
    .ctlWord    (ctlWord),
    .ctlValid   (ctlValid),
    .ctlToB     (ctlToB)
  );
endmodule

// File: tb/sim_pcm_slot_port.sv
`timescale 1ns/1ps
module sim_pcm_slot_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameSyncN = 1'b1;
  logic [1:0] regSel = 2'b00;
  logic       serDataIn = 1'b0;
  logic       serCtlIn = 1'b0;
  logic       loopbackEn = 1'b0;
  logic [7:0] txWord = 8'h00;
  logic       serDataOut, serDataOe, rxValid, ctlValid, ctlToB;
  logic [7:0] rxWord, ctlWord;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] expRx = 8'h00;

  always #4 clk = ~clk;

  pcm_slot_port u0 (
    .clk(clk), .rstN(rstN), .frameSyncN(frameSyncN), .regSel(regSel),
    .serDataIn(serDataIn), .serCtlIn(serCtlIn), .loopbackEn(loopbackEn),
    .txWord(txWord), .serDataOut(serDataOut), .serDataOe(serDataOe),
    .rxWord(rxWord), .rxValid(rxValid), .ctlWord(ctlWord),
    .ctlValid(ctlValid), .ctlToB(ctlToB)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] sentWord(input logic lb, input logic [7:0] tx, input logic [7:0] last);
    return lb ? last : tx;
  endfunction

  // one slot; holdLow keeps frame sync low through the whole slot and beyond
  task automatic runSlot(input logic [7:0] tx, input logic [7:0] din, input logic [7:0] ctl,
                         input logic [1:0] sel, input logic lb, input logic holdLow);
    logic isB;
    logic [7:0] expOut;
    isB = (sel == 2'b10);
    expOut = sentWord(lb, tx, expRx);
    @(negedge clk); #1;
    frameSyncN = 1'b0; regSel = sel; txWord = tx; loopbackEn = lb;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      serDataIn = din[7-k];
      serCtlIn  = ctl[7-k];
      if (k == 0 && !holdLow) frameSyncN = 1'b1;
      if (k == 1) begin
        txWord = ~tx; loopbackEn = ~lb; regSel = ~sel; // R9 R7 sampled at start only
      end
      #2;
      chk(k == 0 ? "R2 oe" : "R3 oe", {7'd0, serDataOe}, {7'd0, !isB});
      chk(k == 0 ? "R2 msb" : "R3 bit", {7'd0, serDataOut}, {7'd0, isB ? 1'b0 : expOut[7-k]});
      if (k == 0) begin
        chk("R8 rx strobe low", {7'd0, rxValid}, 8'd0);
        chk("R8 ctl strobe low", {7'd0, ctlValid}, 8'd0);
      end
    end
    @(posedge clk); #3;
    chk(holdLow ? "R5 released" : "R3 released", {7'd0, serDataOe}, 8'd0);
    chk("R3 out zero", {7'd0, serDataOut}, 8'd0);
    chk("R6 ctl word", ctlWord, ctl);
    chk("R8 ctl strobe", {7'd0, ctlValid}, 8'd1);
    chk("R7 target", {7'd0, ctlToB}, {7'd0, isB});
    chk("R8 rx strobe", {7'd0, rxValid}, {7'd0, !isB});
    if (!isB) expRx = din;
    chk(isB ? "R7 rx kept" : "R4 rx word", rxWord, expRx);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #3;
      chk("R3 idle oe", {7'd0, serDataOe}, 8'd0);
    end
  endtask

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0DEC5));
    // R1 reset state
    repeat (3) @(posedge clk);
    #3;
    chk("R1 oe", {7'd0, serDataOe}, 8'd0);
    chk("R1 rx", rxWord, 8'd0);
    chk("R1 ctl", ctlWord, 8'd0);
    chk("R1 strobes", {6'd0, rxValid, ctlValid}, 8'd0);
    @(negedge clk); rstN = 1'b1;
    idle(3);
    chk("R1 after release", {7'd0, serDataOut}, 8'd0);

    runSlot(8'hA5, 8'h3C, 8'h96, 2'b00, 1'b0, 1'b0);
    idle(5);
    runSlot(8'h5A, 8'hC3, 8'h69, 2'b01, 1'b0, 1'b0);
    idle(2);
    runSlot(8'hFF, 8'h00, 8'hF0, 2'b10, 1'b0, 1'b0); // R7 B slot
    idle(4);
    runSlot(8'h00, 8'hFF, 8'h0F, 2'b00, 1'b1, 1'b0); // R9 sends C3
    idle(3);
    runSlot(8'h81, 8'h7E, 8'h01, 2'b11, 1'b1, 1'b1); // R5 hold low, R9 sends FF
    runSlot(8'h12, 8'h34, 8'h80, 2'b01, 1'b0, 1'b0); // starts right after
    idle(2);

    for (int n = 0; n < 80; n++) begin
      logic [7:0] tx, din, ctl;
      logic [1:0] sel;
      logic lb, hl;
      tx  = 8'($urandom);
      din = 8'($urandom);
      ctl = 8'($urandom);
      sel = 2'($urandom);
      lb  = 1'($urandom);
      hl  = ($urandom % 5) == 0;
      runSlot(tx, din, ctl, sel, lb, hl);
      if (!hl) idle(int'($urandom % 6));
    end
    frameSyncN = 1'b1;
    idle(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule